// File: doc/BRIEF.md
# Signed-Count Double-Word Logical Shifter

This unit executes one instruction: a logical shift of a 32-bit value held in two adjacent 16-bit registers, where the shift amount is a signed 16-bit value taken from a third register. A non-negative count shifts the pair toward the most significant end. A negative count is read as two's complement and shifts the pair toward the least significant end by its magnitude. Vacated positions always fill with zeros.

After a shift, the unit rewrites the register pair and a three-way condition status that classifies the result as zero, negative or positive. If the count magnitude is too large, the unit changes no register and no status. Instead it raises a sticky fixed-point overflow pending bit. The block contains its own 16-entry, 16-bit register file with a load port and a read port, so a whole instruction can be set up and inspected from outside. The instruction runs through a start/done handshake and takes a fixed number of cycles.

Top module: `dword_sshift`

## Requirements
- R1: The instruction word is decoded as opcode in bits 15:8, which must equal 0x6D, first-register index RA in bits 7:4, and count-register index RB in bits 3:0.
- R2: When the count register holds a value from 1 to 31, the 32-bit value {reg[RA], reg[RA+1]}, with reg[RA] as the upper half, is shifted toward the MSB by that amount with zero fill and written back with reg[RA] receiving bits 31:16.
- R3: When the count is from -1 to -31, the pair is shifted toward the LSB by the count's magnitude with zero fill and written back.
- R4: A count of zero leaves both registers unchanged but still updates the condition status from the unchanged pair.
- R5: After an in-range shift, cs becomes 4'b0010 for a zero result, 4'b0001 when result bit 31 is 1, and 4'b0100 otherwise.
- R6: A count of 32 or more, or -32 or less (including -32768), sets ovf_irq to 1 until reset and changes no register and not cs.
- R7: The second register of the pair is (RA+1) modulo 16, so RA = 15 pairs with register 0.
- R8: The count is read before any write. When RA equals RB, that register ends up holding the shifted upper half. Otherwise RB is unchanged unless it is the lower register of the pair.
- R9: A start seen while idle produces done high for exactly one cycle, three clock edges later. A start asserted while busy is ignored, and the instruction in flight uses the word latched at its own start.
- R10: When the opcode is not 0x6D, illegal is high together with done, and no register, cs or ovf_irq changes.
- R11: After reset, all registers, cs, ovf_irq, done and illegal are zero.
- R12: While the unit is idle, ld_en writes ld_data to register ld_addr. rd_data always shows register rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| instr | input | 16 | Instruction word: opcode, RA, RB |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Opcode not recognised, valid with done |
| cs | output | 4 | Condition status |
| ovf_irq | output | 1 | Sticky fixed-point overflow pending bit |
| wr_hi_en | output | 1 | Writing shifted upper half to RA this cycle |
| wr_lo_en | output | 1 | Writing shifted lower half to RA+1 this cycle |
| ld_en | input | 1 | Register file load strobe (idle only) |
| ld_addr | input | 4 | Register file load index |
| ld_data | input | 16 | Register file load data |
| rd_addr | input | 4 | Register file read index |
| rd_data | output | 16 | Register file read data |

## Verification
The bench targets the range edges of the count: 31 and -31 must shift, while 32, -32, 32767 and -32768 must trap. A design that negates -32768 without checking would wrap it to a legal-looking value and shift, or would write the pair on overflow. It places RA at 15 to catch a pair that does not wrap to register 0. It sets RA equal to RB, and RB to RA+1, to catch a count read after the write, or a result lost to the count register. A zero count must still refresh cs from the unchanged pair. The bench also sends illegal opcodes and starts during busy cycles, and random trials compare every register, cs and the overflow bit against a bench model.

// File: rtl/dword_sshift.sv
module dword_sshift #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter logic [7:0] OPC = 8'h6D
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [15:0]             instr,
  output logic                    done,
  output logic                    illegal,
  output logic [3:0]              cs,
  output logic                    ovf_irq,
  output logic                    wr_hi_en,
  output logic                    wr_lo_en,
  input  logic                    ld_en,
  input  logic [$clog2(NREG)-1:0] ld_addr,
  input  logic [DW-1:0]           ld_data,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [DW-1:0]           rd_data
);
  localparam int AW = $clog2(NREG);
  localparam int PW = 2 * DW;
  localparam int SW = $clog2(PW);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} st_t;
  st_t st;

  logic [DW-1:0] rf [NREG];
  logic [15:0]   ir;
  logic [DW-1:0] hi_q, lo_q;
  logic signed [DW-1:0] cnt_q;
  logic          bad_q;

  wire [AW-1:0] ra    = ir[4+AW-1:4];
  wire [AW-1:0] rb    = ir[AW-1:0];
  wire [AW-1:0] ra_n  = ra + 1'b1;
  wire          legal = (ir[15:8] == OPC);

  logic          in_rng;
  logic [SW-1:0] shamt;
  logic [PW-1:0] pair, res;
  logic [3:0]    cs_n;

  always_comb begin
    pair   = {hi_q, lo_q};
    in_rng = (cnt_q < PW) && (cnt_q > -PW);
    shamt  = cnt_q[DW-1] ? SW'(-cnt_q) : SW'(cnt_q);
    res    = cnt_q[DW-1] ? (pair >> shamt) : (pair << shamt);
    if (res == '0)      cs_n = 4'b0010;
    else if (res[PW-1]) cs_n = 4'b0001;
    else                cs_n = 4'b0100;
  end

  assign wr_hi_en = (st == S_WR) && legal && in_rng;
  assign wr_lo_en = wr_hi_en;
  assign done     = (st == S_DONE);
  assign illegal  = done && bad_q;
  assign rd_data  = rf[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ir      <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
      cs      <= '0;
      ovf_irq <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ld_en) rf[ld_addr] <= ld_data;
          if (start) begin
            ir <= instr;
            st <= S_RD;
          end
        end
        S_RD: begin
          hi_q  <= rf[ra];
          lo_q  <= rf[ra_n];
          cnt_q <= rf[rb];
          st    <= S_WR;
        end
        S_WR: begin
          bad_q <= !legal;
          if (legal && !in_rng) ovf_irq <= 1'b1;
          if (wr_hi_en) begin
            rf[ra]   <= res[PW-1:DW];
            rf[ra_n] <= res[DW-1:0];
            cs       <= cs_n;
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == S_IDLE) |=> ##2 done);

  // R6
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_irq) |-> $past(st == S_WR && !in_rng));

  // R6
  no_overflow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && !in_rng) |=> $stable(cs));

  // R5
  cs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs) <= 1);

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && !legal) |=> (illegal && $stable(cs) && $stable(ovf_irq)));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> ovf_irq);
endmodule

// File: tb/dword_sshift_bench.sv
module dword_sshift_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, ld_en = 1'b0;
  logic [15:0] instr = '0, ld_data = '0;
  logic [3:0]  ld_addr = '0, rd_addr = '0;
  logic        done, illegal, ovf_irq, wr_hi_en, wr_lo_en;
  logic [3:0]  cs;
  logic [15:0] rd_data;

  dword_sshift u_dword_sshift (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .done(done), .illegal(illegal), .cs(cs), .ovf_irq(ovf_irq),
    .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m [16];
  logic [3:0]  m_cs;
  logic        m_ovf;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] cs_of(input logic [31:0] v);
    if (v == 0) return 4'b0010;
    if (v[31])  return 4'b0001;
    return 4'b0100;
  endfunction

  task automatic load(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 4'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    m[a] = d;
  endtask

  task automatic cmp_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 4'(i);
      #1;
      chk(rd_data === m[i], tag, {16'h0, rd_data}, {16'h0, m[i]});
    end
    chk(cs === m_cs, {tag, " cs"}, {28'h0, cs}, {28'h0, m_cs});
    chk(ovf_irq === m_ovf, {tag, " ovf"}, {31'h0, ovf_irq}, {31'h0, m_ovf});
  endtask

  task automatic run(input logic [15:0] w, input bit poke_busy, input string tag);
    int ra, rb, rl, cnt;
    logic [31:0] p, r;
    bit leg;
    ra  = int'(w[7:4]); rb = int'(w[3:0]); rl = (ra + 1) % 16;
    leg = (w[15:8] == 8'h6D);
    cnt = int'($signed(m[rb]));
    p   = {m[ra], m[rl]};
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = poke_busy;
    instr = ~w;
    chk(done === 1'b0, {tag, " R9 early"}, {31'h0, done}, 0);
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b0, {tag, " R9 early2"}, {31'h0, done}, 0);
    @(negedge clk);
    chk(done === 1'b1, {tag, " R9 done"}, {31'h0, done}, 1);
    chk(illegal === !leg, {tag, " R10 illegal"}, {31'h0, illegal}, {31'h0, !leg});
    @(negedge clk);
    chk(done === 1'b0, {tag, " R9 pulse"}, {31'h0, done}, 0);
    if (leg) begin
      if (cnt >= 32 || cnt <= -32) m_ovf = 1'b1;
      else begin
        r = (cnt >= 0) ? (p << cnt) : (p >> (-cnt));
        m[ra] = r[31:16];
        m[rl] = r[15:0];
        m_cs  = cs_of(r);
      end
    end
    cmp_all(tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) m[i] = '0;
    m_cs = '0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && illegal === 1'b0, "R11 reset flags", {30'h0, done, illegal}, 0);
    cmp_all("R11 reset");

    // R12 load path, R2 left shift, R5 codes
    load(2, 16'h1234); load(3, 16'h5678); load(4, 16'd4);
    run(16'h6D24, 0, "R2 left 4");
    load(4, 16'd31);
    run(16'h6D24, 0, "R2 left 31 R5");
    load(2, 16'h8000); load(3, 16'h0001); load(4, 16'hFFFF);
    run(16'h6D24, 0, "R3 right 1");
    load(4, 16'hFFE1);
    run(16'h6D24, 0, "R3 right 31");
    load(2, 16'h0000); load(3, 16'h0001); load(4, 16'hFFFE);
    run(16'h6D24, 0, "R5 zero result");
    load(2, 16'h00F0); load(3, 16'h0F00); load(4, 16'h0000);
    run(16'h6D24, 0, "R4 zero count");
    // R6 range edges
    load(4, 16'd32);
    run(16'h6D24, 0, "R6 plus32");
    load(4, 16'hFFE0);
    run(16'h6D24, 0, "R6 minus32");
    load(4, 16'h8000);
    run(16'h6D24, 0, "R6 min neg");
    load(4, 16'h7FFF);
    run(16'h6D24, 0, "R6 max pos");
    // R7 wrap, R8 aliasing
    load(15, 16'hA5A5); load(0, 16'h3C3C); load(7, 16'd8);
    run(16'h6DF7, 0, "R7 wrap");
    load(5, 16'd3); load(6, 16'h8001);
    run(16'h6D55, 0, "R8 ra eq rb");
    load(8, 16'h4001); load(9, 16'hFFFD);
    run(16'h6D89, 0, "R8 rb eq ra plus1");
    // R10 illegal, R9 busy start ignored
    run(16'h6C24, 0, "R10 bad opcode");
    run(16'h0000, 0, "R10 zero word");
    load(4, 16'd5);
    run(16'h6D24, 1, "R9 busy start");
    // R1 random decode and shifts
    for (int t = 0; t < 300; t++) begin
      logic [15:0] w;
      int a;
      a = int'($urandom_range(15, 0));
      if ($urandom_range(3, 0) == 0) load(a, 16'($urandom));
      else load(a, 16'($signed($urandom_range(80, 0)) - 40));
      load(int'($urandom_range(15, 0)), 16'($urandom));
      w = {($urandom_range(7, 0) == 0) ? 8'($urandom) : 8'h6D, 4'($urandom), 4'(a)};
      run(w, bit'($urandom_range(1, 0)), "R1 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule